// File: doc/BRIEF.md
# Serial Transmitter with Flow Control and Infrared Encoding

This block turns queued bytes into asynchronous serial frames. Bytes are written into a small internal queue; a shift engine pulls one out at a character boundary and sends a start bit (low), eight data bits least significant first, and a stop bit (high). Each bit lasts 16 oversample ticks, or 8 when the fast-rate select is set. A single-cycle `baud_tick` pulse supplies the oversample period. The line rests high between frames.

A frame may begin only when both the global enable and the transmit enable are set. When clear-to-send gating is on, the `cts` input must also be high. These conditions are examined only when a frame is about to start, so a frame in flight always finishes. An optional infrared encoder replaces the line with short active-high pulses for zero bits. Its pulse length is either a fixed fraction of the bit, or three periods of a separate low-power reference tick. A loopback switch sends the encoded line to the internal receive path and parks the pin at its idle level. A sticky interrupt flag reports either that the queue has drained to half full, or that the serializer has sent its last stop bit with nothing left queued. A clear strobe resets the flag.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `tx_pin` is high, `tx_irq` is low, and with loopback off `rx_core` follows `rx_pin`.
- R2: A frame is one low start bit, eight data bits least significant bit first, and one high stop bit. With `fast_sel` low, each bit lasts 16 `baud_tick` pulses. A frame starts on a `baud_tick`.
- R3: With `fast_sel` high when a frame starts, each bit of that frame lasts 8 `baud_tick` pulses.
- R4: No frame starts unless `en_global` and `en_tx` are both high. Bytes written meanwhile stay queued and are sent once both are set.
- R5: Clearing an enable during a frame lets that frame finish through its stop bit, and then no further frame starts.
- R6: With `cts_en` high, a frame starts only while `cts` is high, and dropping `cts` mid-frame does not cut the frame short. With `cts_en` low, `cts` has no effect.
- R7: While bytes are queued and starting is allowed, the next start bit follows the previous stop bit with no idle time.
- R8: The queue holds `DEPTH` (default 8) bytes. A write while it is full is dropped.
- R9: With `drain_irq_mode` low, `tx_irq` sets when the queue occupancy falls from above `DEPTH/2` to `DEPTH/2` or below. It stays set until `irq_clr` is pulsed.
- R10: With `drain_irq_mode` high, `tx_irq` sets only after the last stop bit has ended and the queue is empty. It does not set between chained frames.
- R11: With `sir_en` high and `sir_lowpwr` low, the pin rests low. Each zero bit gives one high pulse from the start of the bit, lasting 3 ticks at the 16-tick rate or 2 ticks at the 8-tick rate. One bits give no pulse.
- R12: With `sir_en` and `sir_lowpwr` high, each zero bit gives one high pulse. The pulse starts one clock after the bit begins and ends on the third `lp_tick` after it starts.
- R13: With `loop_en` high, `tx_pin` holds its idle level (high, or low in infrared mode) and `rx_core` carries the encoded transmit line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_global | input | 1 | Global enable |
| en_tx | input | 1 | Transmit enable |
| cts_en | input | 1 | Clear-to-send gating enable |
| fast_sel | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| drain_irq_mode | input | 1 | 1: interrupt on full drain, 0: on queue level |
| sir_en | input | 1 | Infrared pulse encoding enable |
| sir_lowpwr | input | 1 | Infrared low-power pulse timing |
| loop_en | input | 1 | Internal loopback enable |
| push | input | 1 | Write strobe into the byte queue |
| push_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One pulse per oversample period |
| lp_tick | input | 1 | Low-power reference tick |
| cts | input | 1 | Clear to send, active high |
| rx_pin | input | 1 | External receive pin |
| irq_clr | input | 1 | Clears the interrupt flag |
| tx_pin | output | 1 | Serial transmit pin |
| rx_core | output | 1 | Receive path toward the receiver |
| tx_irq | output | 1 | Transmit interrupt flag |

## Verification
The bench targets the boundary between frames. It clears the transmit enable right after a start bit and drops clear-to-send in mid-frame. A design that sampled those controls continuously would truncate the character or send a second one. It fills the queue past capacity and watches the interrupt at the third and fourth frame starts. An overflowing queue would send extra bytes, and a threshold off by one would raise the flag a frame early or late. In drain mode it checks that the flag stays low during the stop bit of a chained frame. An encoder that counted the wrong reference or misread the bit boundary would show the wrong pulse count or width on the pin.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int OSR_SLOW   = 16;
    localparam int OSR_FAST   = 8;
    localparam int TICK_W     = $clog2(OSR_SLOW);
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int SIR_W_SLOW = 3;
    localparam int SIR_W_FAST = 2;
    localparam int LP_TICKS   = 3;
    localparam int LP_CW      = $clog2(LP_TICKS);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ser_state_e;

    typedef struct packed {
        ser_state_e              st;
        logic [FRAME_BITS-1:0]   sh;
        logic [BIT_W-1:0]        bitn;
        logic [TICK_W-1:0]       tick;
        logic                    fast;
        logic                    bit_new;
    } ser_regs_t;

    typedef struct packed {
        logic             on;
        logic [LP_CW-1:0] cnt;
    } lp_regs_t;
endpackage

// File: rtl/uart_txf_fifo.sv
module uart_txf_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [DW-1:0]                 rd_data,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t    q, d;
    logic [DW-1:0] mem [DEPTH];
    logic          do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= push_data;
    end

    assign rd_data = mem[q.rp];
    assign empty   = (q.cnt == '0);
    assign level   = q.cnt;

    // R8: a write into a full queue changes nothing
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH)) && push && !pop |=> (level == CW'(DEPTH)) && $stable(q.wp));
endmodule

// File: rtl/uart_txf_shift.sv
module uart_txf_shift
    import uart_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              allow,
    input  logic              fast_sel,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              busy,
    output logic              serial,
    output logic              zero_bit,
    output logic              bit_start,
    output logic [TICK_W-1:0] tick_idx,
    output logic              cur_fast
);
    ser_regs_t         q, d;
    logic              can_go, load;
    logic [TICK_W-1:0] last;

    always_comb begin
        d         = q;
        d.bit_new = 1'b0;
        load      = 1'b0;
        last      = q.fast ? TICK_W'(OSR_FAST - 1) : TICK_W'(OSR_SLOW - 1);
        can_go    = allow && !fifo_empty;
        if (baud_tick) begin
            if (q.st == ST_IDLE) begin
                load = can_go;
            end else if (q.tick != last) begin
                d.tick = q.tick + TICK_W'(1);
            end else begin
                d.tick = '0;
                if (q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                    load = can_go;
                    if (!can_go) d.st = ST_IDLE;
                end else begin
                    d.sh      = {1'b1, q.sh[FRAME_BITS-1:1]};
                    d.bitn    = q.bitn + BIT_W'(1);
                    d.bit_new = 1'b1;
                end
            end
        end
        if (load) begin
            d.st      = ST_SHIFT;
            d.sh      = {1'b1, fifo_data, 1'b0};
            d.bitn    = '0;
            d.tick    = '0;
            d.fast    = fast_sel;
            d.bit_new = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, sh: '1, bitn: '0, tick: '0, fast: 1'b0, bit_new: 1'b0};
        else        q <= d;
    end

    assign pop       = load;
    assign busy      = (q.st == ST_SHIFT);
    assign serial    = busy ? q.sh[0] : 1'b1;
    assign zero_bit  = busy && !q.sh[0];
    assign bit_start = q.bit_new;
    assign tick_idx  = q.tick;
    assign cur_fast  = q.fast;

    // R4: a frame only begins when starting was allowed
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(allow));
    // R2: the first bit of a frame is low
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !serial);
    // R1: idle line is high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> serial);
    // R5: the engine only stops after the stop bit
    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(q.bitn) == BIT_W'(FRAME_BITS - 1));
endmodule

// File: rtl/uart_txf_sir.sv
module uart_txf_sir
    import uart_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_tick,
    input  logic              lp_mode,
    input  logic              busy,
    input  logic              zero_bit,
    input  logic              bit_start,
    input  logic [TICK_W-1:0] tick_idx,
    input  logic              fast,
    output logic              pulse
);
    lp_regs_t          q, d;
    logic [TICK_W-1:0] width;
    logic              norm_pulse;

    always_comb begin
        width      = fast ? TICK_W'(SIR_W_FAST) : TICK_W'(SIR_W_SLOW);
        norm_pulse = busy && zero_bit && (tick_idx < width);
        d          = q;
        if (bit_start && zero_bit) begin
            d.on  = 1'b1;
            d.cnt = '0;
        end else if (q.on && lp_tick) begin
            if (q.cnt == LP_CW'(LP_TICKS - 1)) begin
                d.on  = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + LP_CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse = lp_mode ? q.on : norm_pulse;

    // R12: a low-power pulse ends only on a reference tick
    p_lp_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.on) |-> $past(lp_tick));
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_txf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_global,
    input  logic              en_tx,
    input  logic              cts_en,
    input  logic              fast_sel,
    input  logic              drain_irq_mode,
    input  logic              sir_en,
    input  logic              sir_lowpwr,
    input  logic              loop_en,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              baud_tick,
    input  logic              lp_tick,
    input  logic              cts,
    input  logic              rx_pin,
    input  logic              irq_clr,
    output logic              tx_pin,
    output logic              rx_core,
    output logic              tx_irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] THRESH = CW'(DEPTH / 2);

    typedef struct packed {
        logic          irq;
        logic          busy_prev;
        logic [CW-1:0] level_prev;
    } top_regs_t;

    top_regs_t         q, d;
    logic [DATA_W-1:0] rd_data;
    logic              empty, pop, busy, serial, zero_bit, bit_start, cur_fast;
    logic              pulse, allow, line, set_irq;
    logic [CW-1:0]     level;
    logic [TICK_W-1:0] tick_idx;

    assign allow = en_global && en_tx && (!cts_en || cts);

    uart_txf_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .rd_data(rd_data), .empty(empty), .level(level)
    );

    uart_txf_shift i_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .allow(allow),
        .fast_sel(fast_sel), .fifo_empty(empty), .fifo_data(rd_data),
        .pop(pop), .busy(busy), .serial(serial), .zero_bit(zero_bit),
        .bit_start(bit_start), .tick_idx(tick_idx), .cur_fast(cur_fast)
    );

    uart_txf_sir i_sir (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .lp_mode(sir_lowpwr),
        .busy(busy), .zero_bit(zero_bit), .bit_start(bit_start),
        .tick_idx(tick_idx), .fast(cur_fast), .pulse(pulse)
    );

    always_comb begin
        d            = q;
        d.busy_prev  = busy;
        d.level_prev = level;
        if (drain_irq_mode) set_irq = q.busy_prev && !busy && empty;
        else                set_irq = (q.level_prev > THRESH) && (level <= THRESH);
        d.irq = set_irq || (q.irq && !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line    = sir_en ? pulse : serial;
    assign tx_pin  = loop_en ? !sir_en : line;
    assign rx_core = loop_en ? line : rx_pin;
    assign tx_irq  = q.irq;

    // R9: in level mode the flag rises only with the queue at or below the threshold
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) && !$past(drain_irq_mode) |-> level <= THRESH);
    // R10: in drain mode the flag rises only with the engine idle and queue empty
    p_irq_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) && $past(drain_irq_mode) |-> $past(!busy && empty));
endmodule

// File: tb/test_uart_tx_flow.sv
module test_uart_tx_flow;
    localparam int TICK_P = 4;
    localparam int LP_P   = 5;
    localparam int DEPTH  = 8;
    localparam int WDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_global = 1'b0, en_tx = 1'b0, cts_en = 1'b0, fast_sel = 1'b0;
    logic drain_irq_mode = 1'b0, sir_en = 1'b0, sir_lowpwr = 1'b0, loop_en = 1'b0;
    logic push = 1'b0, baud_tick = 1'b0, lp_tick = 1'b0, cts = 1'b1;
    logic rx_pin = 1'b1, irq_clr = 1'b0, use_rx = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic tx_pin, rx_core, tx_irq, mon;
    int n_chk = 0, n_bad = 0;

    // {fast_sel, byte}
    localparam logic [8:0] VEC [6] = '{9'h055, 9'h1A3, 9'h000, 9'h1FF, 9'h081, 9'h13C};

    always #4 clk = ~clk;
    assign mon = use_rx ? rx_core : tx_pin;

    uart_tx_flow #(.DEPTH(DEPTH)) i_uart_tx_flow (
        .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_tx(en_tx),
        .cts_en(cts_en), .fast_sel(fast_sel), .drain_irq_mode(drain_irq_mode),
        .sir_en(sir_en), .sir_lowpwr(sir_lowpwr), .loop_en(loop_en),
        .push(push), .push_data(push_data), .baud_tick(baud_tick),
        .lp_tick(lp_tick), .cts(cts), .rx_pin(rx_pin), .irq_clr(irq_clr),
        .tx_pin(tx_pin), .rx_core(rx_core), .tx_irq(tx_irq)
    );

    initial begin
        forever begin
            repeat (TICK_P - 1) @(posedge clk);
            baud_tick <= 1'b1;
            @(posedge clk);
            baud_tick <= 1'b0;
        end
    end

    initial begin
        forever begin
            repeat (LP_P - 1) @(posedge clk);
            lp_tick <= 1'b1;
            @(posedge clk);
            lp_tick <= 1'b0;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1..: actual running expected finished");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        push = 1'b1;
        push_data = b;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic clr_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wait_start(input int limit, output logic ok);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (mon == 1'b0) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // called right after the start bit was seen; returns at the middle of the stop bit
    task automatic recv(input logic fast, output logic [7:0] b, output logic stop_ok);
        int bt;
        logic st;
        bt = (fast ? 8 : 16) * TICK_P;
        repeat (bt / 2) @(negedge clk);
        st = mon;
        for (int i = 0; i < 8; i++) begin
            repeat (bt) @(negedge clk);
            b[i] = mon;
        end
        repeat (bt) @(negedge clk);
        stop_ok = mon && !st;
    endtask

    task automatic measure(input int window, output int np, output int wmin, output int wmax);
        int run;
        run = 0; np = 0; wmin = 100000; wmax = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (tx_pin) run++;
            else if (run > 0) begin
                np++;
                if (run < wmin) wmin = run;
                if (run > wmax) wmax = run;
                run = 0;
            end
        end
    endtask

    task automatic settle();
        repeat (16 * TICK_P) @(negedge clk);
    endtask

    initial begin
        logic ok, sok;
        logic [7:0] b;
        int np, wmin, wmax;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 idle pin", tx_pin, 1);
        chk("R1 irq low", tx_irq, 0);
        rx_pin = 1'b0;
        @(negedge clk);
        chk("R1 rx path", rx_core, 0);
        rx_pin = 1'b1;
        @(negedge clk);
        chk("R1 rx path", rx_core, 1);

        en_global = 1'b1;
        en_tx = 1'b1;

        // R2 / R3: table of frames
        foreach (VEC[k]) begin
            fast_sel = VEC[k][8];
            put(VEC[k][7:0]);
            wait_start(2000, ok);
            chk("R2 frame start", ok, 1);
            recv(VEC[k][8], b, sok);
            chk(VEC[k][8] ? "R3 data fast" : "R2 data", b, VEC[k][7:0]);
            chk("R2 start/stop", sok, 1);
            settle();
        end
        fast_sel = 1'b0;

        // R4: gating by both enables
        en_tx = 1'b0;
        put(8'hC6);
        wait_start(1500, ok);
        chk("R4 no start tx off", ok, 0);
        en_global = 1'b0;
        en_tx = 1'b1;
        wait_start(1500, ok);
        chk("R4 no start global off", ok, 0);
        en_global = 1'b1;
        wait_start(2000, ok);
        chk("R4 start after enable", ok, 1);
        recv(1'b0, b, sok);
        chk("R4 queued data", b, 8'hC6);
        settle();

        // R5: enable cleared mid-frame
        put(8'h3A);
        put(8'h5B);
        wait_start(2000, ok);
        en_tx = 1'b0;
        recv(1'b0, b, sok);
        chk("R5 frame completes", b, 8'h3A);
        chk("R5 stop bit sent", sok, 1);
        wait_start(1500, ok);
        chk("R5 no further frame", ok, 0);
        en_tx = 1'b1;
        wait_start(2000, ok);
        recv(1'b0, b, sok);
        chk("R5 held byte later", b, 8'h5B);
        settle();

        // R6: clear-to-send gating
        cts_en = 1'b1;
        cts = 1'b0;
        put(8'h96);
        wait_start(1500, ok);
        chk("R6 blocked by cts", ok, 0);
        cts = 1'b1;
        wait_start(2000, ok);
        chk("R6 start with cts", ok, 1);
        cts = 1'b0;
        recv(1'b0, b, sok);
        chk("R6 frame not cut", b, 8'h96);
        chk("R6 stop intact", sok, 1);
        settle();
        cts_en = 1'b0;
        put(8'h69);
        wait_start(2000, ok);
        chk("R6 cts ignored", ok, 1);
        recv(1'b0, b, sok);
        chk("R6 cts ignored data", b, 8'h69);
        cts = 1'b1;
        settle();

        // R7: back-to-back frames with no gap
        fast_sel = 1'b1;
        put(8'h12);
        put(8'h34);
        put(8'h56);
        wait_start(2000, ok);
        recv(1'b1, b, sok);
        chk("R7 first", b, 8'h12);
        for (int k = 1; k < 3; k++) begin
            wait_start(8 * TICK_P / 2 + 4, ok);
            chk("R7 no gap", ok, 1);
            recv(1'b1, b, sok);
            chk("R7 chained data", b, (k == 1) ? 8'h34 : 8'h56);
        end
        fast_sel = 1'b0;
        settle();

        // R8 / R9: full queue and level interrupt
        clr_irq();
        en_tx = 1'b0;
        for (int k = 0; k < DEPTH + 2; k++) put(8'h10 + 8'(k));
        chk("R9 no irq while filling", tx_irq, 0);
        en_tx = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            wait_start(2000, ok);
            recv(1'b0, b, sok);
            chk("R8 queued order", b, 8'h10 + 8'(k));
            if (k == 2) chk("R9 above threshold", tx_irq, 0);
            if (k == 3) chk("R9 at threshold", tx_irq, 1);
        end
        wait_start(1500, ok);
        chk("R8 overflow dropped", ok, 0);
        chk("R9 sticky", tx_irq, 1);
        clr_irq();
        chk("R9 cleared", tx_irq, 0);

        // R10: drain interrupt
        drain_irq_mode = 1'b1;
        clr_irq();
        put(8'h11);
        put(8'h22);
        wait_start(2000, ok);
        recv(1'b0, b, sok);
        chk("R10 not between frames", tx_irq, 0);
        wait_start(2000, ok);
        recv(1'b0, b, sok);
        chk("R10 not during stop", tx_irq, 0);
        repeat (16 * TICK_P / 2 + 4) @(negedge clk);
        chk("R10 set after drain", tx_irq, 1);
        drain_irq_mode = 1'b0;
        clr_irq();

        // R11: infrared, proportional pulses
        sir_en = 1'b1;
        @(negedge clk);
        chk("R11 idle low", tx_pin, 0);
        put(8'hF0);
        measure(10 * 16 * TICK_P + 20, np, wmin, wmax);
        chk("R11 pulse count", np, 5);
        chk("R11 width min 16x", wmin, 3 * TICK_P);
        chk("R11 width max 16x", wmax, 3 * TICK_P);
        fast_sel = 1'b1;
        put(8'h0F);
        measure(10 * 8 * TICK_P + 20, np, wmin, wmax);
        chk("R11 pulse count fast", np, 5);
        chk("R11 width 8x", wmin, 2 * TICK_P);
        fast_sel = 1'b0;

        // R12: low-power pulses
        sir_lowpwr = 1'b1;
        put(8'hFE);
        measure(10 * 16 * TICK_P + 20, np, wmin, wmax);
        chk("R12 pulse count", np, 2);
        chk("R12 width low bound", wmin >= 2 * LP_P + 1, 1);
        chk("R12 width high bound", wmax <= 3 * LP_P, 1);
        sir_lowpwr = 1'b0;
        sir_en = 1'b0;
        settle();

        // R13: loopback
        loop_en = 1'b1;
        use_rx = 1'b1;
        rx_pin = 1'b0;
        @(negedge clk);
        chk("R13 rx pin ignored", rx_core, 1);
        fork
            begin
                measure(10 * 16 * TICK_P + 40, np, wmin, wmax);
            end
            begin
                put(8'h5A);
                wait_start(2000, ok);
                recv(1'b0, b, sok);
                chk("R13 looped data", b, 8'h5A);
            end
        join
        chk("R13 pin held idle", np, 0);
        chk("R13 pin level", tx_pin, 1);
        loop_en = 1'b0;
        use_rx = 1'b0;
        rx_pin = 1'b1;

        summary();
    end
endmodule